// File: doc/BRIEF.md
# PATA PIO Cycle Timing Engine

This block is the host-side engine that carries out programmed-I/O cycles to a parallel ATA or CompactFlash device running in True IDE mode. A single-port register bus faces the host. Writing a device-facing port starts one device cycle. Reading a device-facing port also starts a device cycle but returns no device data. The device result is latched into a read-data register, which the host fetches in a second access. Every device cycle has three phases taken from one packed timing register, all counted in controller clocks: address setup, strobe active, and end-of-cycle recovery. The device can stretch the active phase through IORDY when that is enabled.

The host bus uses a `req_i`/`ready_o` handshake. An access completes in the cycle where both are high. Register accesses never wait. A device-port access, or a read-data fetch, that arrives while a device cycle is still running is held in a wait state until that cycle retires. A host can therefore poll the pending field in the status word, or simply issue its accesses back to back. Device completion and INTRQ rising edges are collected in a write-one-to-clear status register, and a mask register gates them onto a single interrupt line.

Top module: `pata_pio_engine`

## Requirements
- R1: The timing register (word 2) packs the setup count in [3:0], the active count in [11:4] and the recovery count in [19:12]. A device cycle holds chip select and address with both strobes high for the setup count, then holds the selected strobe low for the active count, then holds the strobe high for the recovery count with chip select, address and write data still driven. A new cycle may start only after that.
- R2: A phase count of zero lasts exactly one clock.
- R3: Control word 0 bit 0 enables the interface. While it is 0, device-port accesses are accepted without wait but start no cycle: chip selects and strobes stay deasserted and no completion is flagged.
- R4: Config word 1 bit 0 enables IORDY, which must be synchronous to `clk_i`. When the bit is 1, a low `iordy_i` holds the strobe low beyond the active count until IORDY is seen high. When the bit is 0, IORDY has no effect.
- R5: Status word 3 bits [31:28] show the phase of the current cycle: 4'b0001 setup, 4'b0010 active, 4'b0100 recovery, 4'b0000 idle. The other bits read 0.
- R6: `ready_o` is low while `req_i` addresses a device port or the read-data word and a device cycle is in progress. All other accesses complete in the cycle they are presented.
- R7: Task-file words 8 to 15 select command-block chip select `cs_no[0]` with address `addr-8`. Word 16 selects control-block chip select `cs_no[1]` with address 6. These are byte cycles: a write drives `wdata_i[7:0]` on `dd_o[7:0]` with zeros above. A read latches `dd_i[7:0]`, zero-extended, into read-data word 6 when the strobe rises. The launching read returns 0.
- R8: Data word 7 runs a 16-bit cycle on `cs_no[0]` with address 0. When config bit 1 is set, the two bytes are exchanged in both directions, for written data and for latched read data.
- R9: Interrupt status word 4 bit 0 is set when a device cycle completes. Bit 1 is set on an INTRQ rising edge, two clocks after the edge is seen through a two-flop synchronizer. Writing 1 to a bit clears it, and a new set in the same clock wins over the clear.
- R10: `irq_o` is high exactly when some bit of interrupt status word 4 is set and its bit in mask word 5 is also 1.
- R11: Words 0, 1, 2, 5 read back what was written to their defined bits. Reset values are 0, except the timing word, which resets to 20'hFFFFF. Undefined words and device ports read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Host access request |
| we_i | input | 1 | Host access is a write |
| addr_i | input | 5 | Host word address |
| wdata_i | input | 32 | Host write data |
| rdata_o | output | 32 | Host read data, valid when req_i and ready_o |
| ready_o | output | 1 | Access completes this cycle; low is a wait state |
| cs_no | output | 2 | Active-low chip selects: bit 0 command block, bit 1 control block |
| da_o | output | 3 | Device register address |
| dior_no | output | 1 | Active-low read strobe |
| diow_no | output | 1 | Active-low write strobe |
| dd_o | output | 16 | Device data out |
| dd_oe_o | output | 1 | Device data output enable |
| dd_i | input | 16 | Device data in |
| iordy_i | input | 1 | Device ready, synchronous to clk_i |
| intrq_i | input | 1 | Device interrupt request |
| irq_o | output | 1 | Masked interrupt to host |

## Verification
A wrong phase counter or phase state shows up at the strobe and chip-select pins in the very clock where a phase is cut short or drawn out. It also shows up in the pending field of the status word and in `ready_o` on the next access that has to wait. A wrong latch edge or a wrong byte order appears only later, when the host fetches the read-data word. For that reason every fetch is compared against a value computed at the strobe's rising edge. Interrupt-status faults appear at `irq_o` one clock after the setting event once the bit is unmasked. The bench also compares the whole pin set against a behavioural model on every clock.

// File: rtl/pata_pio_pkg.sv
package pata_pio_pkg;
  localparam int HOST_W  = 32;
  localparam int DEV_W   = 16;
  localparam int SETUP_W = 4;
  localparam int ACT_W   = 8;
  localparam int REC_W   = 8;
  localparam int TIM_W   = SETUP_W + ACT_W + REC_W;
  localparam int NIRQ    = 2;
  localparam int PEND_W  = 4;
  localparam int DA_W    = 3;

  // host word map
  localparam int A_CTRL = 0;
  localparam int A_CFG  = 1;
  localparam int A_TIM  = 2;
  localparam int A_STAT = 3;
  localparam int A_IRQ  = 4;
  localparam int A_MASK = 5;
  localparam int A_RDAT = 6;
  localparam int A_DATA = 7;
  localparam int A_TF   = 8;
  localparam int TF_N   = 8;
  localparam int A_ALT  = 16;
  localparam int ALT_DA = 6;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_RECOV  = 2'd3
  } phase_e;

  typedef struct packed {
    logic [REC_W-1:0]   recov;
    logic [ACT_W-1:0]   active;
    logic [SETUP_W-1:0] setup;
  } pio_tim_t;
endpackage

// File: rtl/pata_lane_swap.sv
module pata_lane_swap #(
  parameter int W = 16
) (
  input  logic         swap_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] d_o
);
  localparam int NB = W / 8;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign d_o[b*8 +: 8] = swap_i ? d_i[(NB-1-b)*8 +: 8] : d_i[b*8 +: 8];
  end
endmodule

// File: rtl/pata_phase_seq.sv
module pata_phase_seq
  import pata_pio_pkg::*;
#(
  parameter int CNT_W = (ACT_W > REC_W) ? ACT_W : REC_W
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  pio_tim_t tim_i,
  input  logic     iordy_en_i,
  input  logic     iordy_i,
  output phase_e   phase_o,
  output logic     strobe_end_o,
  output logic     done_o
);
  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last;

  function automatic logic [CNT_W-1:0] at_least1(input logic [CNT_W-1:0] n);
    return (n == '0) ? CNT_W'(1) : n;
  endfunction

  assign last         = (cnt_q == CNT_W'(1));
  assign strobe_end_o = (ph_q == PH_ACTIVE) && last && (!iordy_en_i || iordy_i);
  assign done_o       = (ph_q == PH_RECOV) && last;
  assign phase_o      = ph_q;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    unique case (ph_q)
      PH_IDLE: if (start_i) begin
        ph_d  = PH_SETUP;
        cnt_d = at_least1(CNT_W'(tim_i.setup));
      end
      PH_SETUP: if (last) begin
        ph_d  = PH_ACTIVE;
        cnt_d = at_least1(CNT_W'(tim_i.active));
      end else cnt_d = cnt_q - 1'b1;
      PH_ACTIVE: if (!last) cnt_d = cnt_q - 1'b1;
        else if (strobe_end_o) begin
          ph_d  = PH_RECOV;
          cnt_d = at_least1(CNT_W'(tim_i.recov));
        end
      PH_RECOV: if (last) ph_d = PH_IDLE;
        else cnt_d = cnt_q - 1'b1;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/pata_irq_unit.sv
module pata_irq_unit
  import pata_pio_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            intrq_i,
  input  logic            done_i,
  input  logic [NIRQ-1:0] clr_i,
  input  logic [NIRQ-1:0] mask_i,
  output logic [NIRQ-1:0] stat_o,
  output logic            irq_o
);
  logic [SYNC:0]     sh_q;
  logic [NIRQ-1:0]   stat_q, set;

  assign set    = {sh_q[SYNC-1] & ~sh_q[SYNC], done_i};
  assign stat_o = stat_q;
  assign irq_o  = |(stat_q & mask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      stat_q <= '0;
    end else begin
      sh_q   <= {sh_q[SYNC-1:0], intrq_i};
      stat_q <= (stat_q & ~clr_i) | set;
    end
  end
endmodule

// File: rtl/pata_pio_engine.sv
module pata_pio_engine
  import pata_pio_pkg::*;
#(
  parameter int          ADDR_W  = 5,
  parameter logic [19:0] TIM_RST = 20'hFFFFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              ready_o,
  output logic [1:0]        cs_no,
  output logic [2:0]        da_o,
  output logic              dior_no,
  output logic              diow_no,
  output logic [15:0]       dd_o,
  output logic              dd_oe_o,
  input  logic [15:0]       dd_i,
  input  logic              iordy_i,
  input  logic              intrq_i,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] AD_CTRL = ADDR_W'(A_CTRL);
  localparam logic [ADDR_W-1:0] AD_CFG  = ADDR_W'(A_CFG);
  localparam logic [ADDR_W-1:0] AD_TIM  = ADDR_W'(A_TIM);
  localparam logic [ADDR_W-1:0] AD_STAT = ADDR_W'(A_STAT);
  localparam logic [ADDR_W-1:0] AD_IRQ  = ADDR_W'(A_IRQ);
  localparam logic [ADDR_W-1:0] AD_MASK = ADDR_W'(A_MASK);
  localparam logic [ADDR_W-1:0] AD_RDAT = ADDR_W'(A_RDAT);
  localparam logic [ADDR_W-1:0] AD_DATA = ADDR_W'(A_DATA);
  localparam logic [ADDR_W-1:0] AD_TF   = ADDR_W'(A_TF);
  localparam logic [ADDR_W-1:0] AD_TFE  = ADDR_W'(A_TF + TF_N);
  localparam logic [ADDR_W-1:0] AD_ALT  = ADDR_W'(A_ALT);

  logic              ctrl_en_q;
  logic [1:0]        cfg_q;
  pio_tim_t          tim_q;
  logic [NIRQ-1:0]   mask_q;
  logic [DEV_W-1:0]  rd_q, wd_q;
  logic              wr_q, byte_q;
  logic [1:0]        cs_q;
  logic [DA_W-1:0]   da_q;

  logic is_tf, is_alt, is_data, dev_acc, needs_idle, busy, accept, start;
  logic strobe_end, cyc_done;
  phase_e            phase;
  logic [PEND_W-1:0] pend;
  logic [NIRQ-1:0]   irq_stat, irq_clr;
  logic [DEV_W-1:0]  wd_sw, rd_sw;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i[HOST_W-1:TIM_W];

  // address decode
  assign is_tf      = (addr_i >= AD_TF) && (addr_i < AD_TFE);
  assign is_alt     = (addr_i == AD_ALT);
  assign is_data    = (addr_i == AD_DATA);
  assign dev_acc    = is_tf || is_alt || is_data;
  assign needs_idle = dev_acc || (addr_i == AD_RDAT);
  assign busy       = (phase != PH_IDLE);
  assign ready_o    = !(req_i && needs_idle && busy);
  assign accept     = req_i && ready_o;
  assign start      = accept && dev_acc && ctrl_en_q;
  assign irq_clr    = (accept && we_i && addr_i == AD_IRQ) ? wdata_i[NIRQ-1:0] : '0;
  assign pend       = {1'b0, phase == PH_RECOV, phase == PH_ACTIVE, phase == PH_SETUP};

  pata_lane_swap #(.W(DEV_W)) u_wswap (.swap_i(cfg_q[1]), .d_i(wdata_i[DEV_W-1:0]), .d_o(wd_sw));
  pata_lane_swap #(.W(DEV_W)) u_rswap (.swap_i(cfg_q[1]), .d_i(dd_i), .d_o(rd_sw));

  pata_phase_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .tim_i       (tim_q),
    .iordy_en_i  (cfg_q[0]),
    .iordy_i     (iordy_i),
    .phase_o     (phase),
    .strobe_end_o(strobe_end),
    .done_o      (cyc_done)
  );

  pata_irq_unit u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .intrq_i(intrq_i),
    .done_i (cyc_done),
    .clr_i  (irq_clr),
    .mask_i (mask_q),
    .stat_o (irq_stat),
    .irq_o  (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_en_q <= 1'b0;
      cfg_q     <= '0;
      tim_q     <= pio_tim_t'(TIM_RST);
      mask_q    <= '0;
    end else if (accept && we_i) begin
      unique case (addr_i)
        AD_CTRL: ctrl_en_q <= wdata_i[0];
        AD_CFG:  cfg_q     <= wdata_i[1:0];
        AD_TIM:  tim_q     <= pio_tim_t'(wdata_i[TIM_W-1:0]);
        AD_MASK: mask_q    <= wdata_i[NIRQ-1:0];
        default: ;
      endcase
    end
  end

  // cycle attributes captured at launch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= 1'b0;
      byte_q <= 1'b0;
      cs_q   <= 2'b11;
      da_q   <= '0;
      wd_q   <= '0;
    end else if (start) begin
      wr_q   <= we_i;
      byte_q <= !is_data;
      cs_q   <= is_alt ? 2'b01 : 2'b10;
      da_q   <= is_alt ? DA_W'(ALT_DA) : (is_data ? '0 : addr_i[DA_W-1:0]);
      wd_q   <= is_data ? wd_sw : {8'h00, wdata_i[7:0]};
    end
  end

  // read result captured on strobe release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else if (strobe_end && !wr_q) rd_q <= byte_q ? {8'h00, dd_i[7:0]} : rd_sw;
  end

  assign cs_no   = busy ? cs_q : 2'b11;
  assign da_o    = busy ? da_q : '0;
  assign dior_no = !((phase == PH_ACTIVE) && !wr_q);
  assign diow_no = !((phase == PH_ACTIVE) && wr_q);
  assign dd_oe_o = busy && wr_q;
  assign dd_o    = dd_oe_o ? wd_q : '0;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      AD_CTRL: rdata_o = {31'b0, ctrl_en_q};
      AD_CFG:  rdata_o = {30'b0, cfg_q};
      AD_TIM:  rdata_o = {{(HOST_W-TIM_W){1'b0}}, tim_q};
      AD_STAT: rdata_o = {pend, {(HOST_W-PEND_W){1'b0}}};
      AD_IRQ:  rdata_o = {{(HOST_W-NIRQ){1'b0}}, irq_stat};
      AD_MASK: rdata_o = {{(HOST_W-NIRQ){1'b0}}, mask_q};
      AD_RDAT: rdata_o = {{(HOST_W-DEV_W){1'b0}}, rd_q};
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/pata_pio_checker.sv
module pata_pio_checker
  import pata_pio_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic              ready_o,
  input logic [1:0]        cs_no,
  input logic              dior_no,
  input logic              diow_no,
  input logic              irq_o,
  input logic              en,
  input logic [PEND_W-1:0] pend,
  input logic [NIRQ-1:0]   stat,
  input logic [NIRQ-1:0]   mask,
  input logic              done
);
  logic dev;
  assign dev = (addr_i == ADDR_W'(A_DATA)) || (addr_i == ADDR_W'(A_ALT)) ||
               ((addr_i >= ADDR_W'(A_TF)) && (addr_i < ADDR_W'(A_TF + TF_N)));

  assert_strobe_excl_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!dior_no && !diow_no));

  assert_strobe_cs_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dior_no || !diow_no) |-> (cs_no != 2'b11));

  assert_launch_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o && dev && en) |=> (pend == 4'b0001));

  assert_pend_code_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pend) && !pend[3]);

  assert_disabled_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && pend == '0) |=> (pend == '0));

  assert_wait_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !ready_o) |-> (pend != '0));

  assert_w1c_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o && we_i && addr_i == ADDR_W'(A_IRQ) && wdata_i[0] && !done) |=> !stat[0]);

  assert_irq_mask_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(stat[1]) && mask[1]) |-> irq_o);
endmodule

bind pata_pio_engine pata_pio_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .req_i  (req_i),
  .we_i   (we_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .ready_o(ready_o),
  .cs_no  (cs_no),
  .dior_no(dior_no),
  .diow_no(diow_no),
  .irq_o  (irq_o),
  .en     (ctrl_en_q),
  .pend   (pend),
  .stat   (irq_stat),
  .mask   (mask_q),
  .done   (cyc_done)
);

// File: tb/tb_pata_pio_engine.sv
`timescale 1ns/1ps
module tb_pata_pio_engine;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_o;
  logic        ready_o;
  logic [1:0]  cs_no;
  logic [2:0]  da_o;
  logic        dior_no, diow_no, dd_oe_o, irq_o;
  logic [15:0] dd_o;
  logic [15:0] dev_rd = 16'h0000;
  logic        iordy = 1'b1, intrq = 1'b0;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pata_pio_engine dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata_o), .ready_o(ready_o), .cs_no(cs_no),
    .da_o(da_o), .dior_no(dior_no), .diow_no(diow_no), .dd_o(dd_o),
    .dd_oe_o(dd_oe_o), .dd_i(dev_rd), .iordy_i(iordy), .intrq_i(intrq),
    .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          m_ph, m_left, m_stat, m_tim;
  bit          m_en, m_wr, m_s1, m_s2, m_s3;
  logic [1:0]  m_cfg, m_mask, m_cs;
  logic [2:0]  m_da;
  logic [15:0] m_wd, m_rd;
  bit          m_byte;

  function automatic bit is_dev(input logic [4:0] a);
    return (a == 7) || (a >= 8 && a <= 15) || (a == 16);
  endfunction
  function automatic int max1(input int n);
    return (n == 0) ? 1 : n;
  endfunction
  function automatic logic [15:0] sw(input logic [15:0] d);
    return {d[7:0], d[15:8]};
  endfunction
  function automatic bit m_ready();
    return !(req && (is_dev(addr) || addr == 6) && m_ph != 0);
  endfunction
  function automatic logic [31:0] m_rdata(input logic [4:0] a);
    case (a)
      0: return {31'b0, m_en};
      1: return {30'b0, m_cfg};
      2: return m_tim;
      3: return {1'b0, m_ph == 3, m_ph == 2, m_ph == 1, 28'b0};
      4: return m_stat;
      5: return {30'b0, m_mask};
      6: return {16'b0, m_rd};
      default: return 32'b0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ph = 0; m_left = 0; m_stat = 0; m_tim = 'hFFFFF; m_en = 0; m_wr = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_cfg = 0; m_mask = 0; m_cs = 2'b11;
      m_da = 0; m_wd = 0; m_rd = 0; m_byte = 0;
    end else begin
      bit acc;
      int set, clr;
      acc = req && m_ready();
      set = 0;
      if (m_ph == 3 && m_left == 1) set |= 1;
      if (m_s2 && !m_s3) set |= 2;
      clr = (acc && we && addr == 4) ? int'(wdata[1:0]) : 0;
      m_stat = (m_stat & ~clr) | set;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = intrq;
      case (m_ph)
        1: if (m_left == 1) begin m_ph = 2; m_left = max1((m_tim >> 4) & 'hFF); end
           else m_left--;
        2: if (m_left > 1) m_left--;
           else if (!m_cfg[0] || iordy) begin
             if (!m_wr) m_rd = m_byte ? {8'h00, dev_rd[7:0]} : (m_cfg[1] ? sw(dev_rd) : dev_rd);
             m_ph = 3; m_left = max1((m_tim >> 12) & 'hFF);
           end
        3: if (m_left == 1) m_ph = 0; else m_left--;
        default: ;
      endcase
      if (acc && we) case (addr)
        0: m_en = wdata[0];
        1: m_cfg = wdata[1:0];
        2: m_tim = int'(wdata[19:0]);
        5: m_mask = wdata[1:0];
        default: ;
      endcase
      if (acc && is_dev(addr) && m_en) begin
        m_ph = 1; m_left = max1(m_tim & 'hF); m_wr = we;
        m_byte = (addr != 7);
        m_cs = (addr == 16) ? 2'b01 : 2'b10;
        m_da = (addr == 16) ? 3'd6 : (addr == 7 ? 3'd0 : addr[2:0]);
        m_wd = (addr == 7) ? (m_cfg[1] ? sw(wdata[15:0]) : wdata[15:0]) : {8'h00, wdata[7:0]};
      end
    end
  end

  // per-cycle comparison, away from the active edge
  int          wr_low = 0, rd_low = 0, busy_cnt = 0;
  logic [15:0] last_wr_dd = '0;
  logic [2:0]  last_da = '0;
  logic [1:0]  last_cs = 2'b11;

  always @(negedge clk) begin
    #2;
    if (rst_ni && !finished) begin
      bit busy;
      busy = (m_ph != 0);
      check("R1 cs_no", {30'b0, cs_no}, {30'b0, busy ? m_cs : 2'b11});
      check("R1 da_o", {29'b0, da_o}, {29'b0, busy ? m_da : 3'd0});
      check("R1 dior_no", {31'b0, dior_no}, {31'b0, !(m_ph == 2 && !m_wr)});
      check("R1 diow_no", {31'b0, diow_no}, {31'b0, !(m_ph == 2 && m_wr)});
      check("R1 dd_oe_o", {31'b0, dd_oe_o}, {31'b0, busy && m_wr});
      if (busy && m_wr) check("R8 dd_o", {16'b0, dd_o}, {16'b0, m_wd});
      check("R10 irq_o", {31'b0, irq_o}, {31'b0, |(m_stat[1:0] & m_mask)});
      check("R6 ready_o", {31'b0, ready_o}, {31'b0, m_ready()});
      if (req && !we && m_ready()) check("R11 rdata_o", rdata_o, m_rdata(addr));
      if (!diow_no) begin wr_low++; last_wr_dd = dd_o; last_da = da_o; last_cs = cs_no; end
      if (!dior_no) begin rd_low++; last_da = da_o; last_cs = cs_no; end
      if (cs_no != 2'b11) busy_cnt++;
    end
  end

  // ---------------- host bus tasks ----------------
  task automatic host_acc(input bit w, input logic [4:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output int waits);
    bit r;
    req = 1'b1; we = w; addr = a; wdata = d; waits = 0;
    forever begin
      #1; r = ready_o; rd = rdata_o;
      @(posedge clk);
      if (r) break;
      waits++;
      @(negedge clk);
    end
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    logic [31:0] x; int w;
    host_acc(1'b1, a, d, x, w);
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    int w;
    host_acc(1'b0, a, 32'h0, d, w);
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    do rd(5'd3, s); while (s[31:28] != 4'h0);
  endtask

  task automatic clr_cnt();
    wr_low = 0; rd_low = 0; busy_cnt = 0;
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] v;
    int w;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // reset state
    check("R11 reset cs_no", {30'b0, cs_no}, 32'h3);
    check("R11 reset strobes", {30'b0, dior_no, diow_no}, 32'h3);
    check("R10 reset irq", {31'b0, irq_o}, 32'h0);
    rd(5'd0, v); check("R11 ctrl reset", v, 32'h0);
    rd(5'd2, v); check("R11 timing reset", v, 32'h000FFFFF);
    rd(5'd3, v); check("R5 idle status", v, 32'h0);

    // disabled: no cycle, no completion
    clr_cnt();
    wr(5'd7, 32'h1111);
    repeat (20) @(negedge clk);
    check("R3 no strobe while disabled", wr_low, 0);
    check("R3 no select while disabled", busy_cnt, 0);
    rd(5'd4, v); check("R3 no completion flag", v, 32'h0);

    wr(5'd0, 32'h1);
    wr(5'd2, 32'h02032);
    rd(5'd2, v); check("R11 timing readback", v, 32'h02032);

    // task-file write: S2 A3 R2
    clr_cnt();
    wr(5'd10, 32'h1A5);
    wait_idle();
    check("R1 active length", wr_low, 3);
    check("R7 byte write data", {16'b0, last_wr_dd}, 32'h00A5);
    check("R7 tf address", {29'b0, last_da}, 32'h2);
    check("R7 tf chip select", {30'b0, last_cs}, 32'h2);

    // pending field during setup
    wr(5'd2, 32'h02033);
    wr(5'd9, 32'h33);
    rd(5'd3, v); check("R5 setup code", v, 32'h10000000);
    wait_idle();

    // task-file read, posted; fetch waits
    dev_rd = 16'hA5C3;
    wr(5'd2, 32'h02032);
    rd(5'd11, v); check("R7 launching read returns 0", v, 32'h0);
    host_acc(1'b0, 5'd6, 32'h0, v, w);
    check("R7 latched byte", v, 32'h000000C3);
    check("R6 fetch waited", {31'b0, w > 0}, 32'h1);

    // control-block access
    clr_cnt();
    wr(5'd16, 32'h0E);
    wait_idle();
    check("R7 alt select", {30'b0, last_cs}, 32'h1);
    check("R7 alt address", {29'b0, last_da}, 32'h6);

    // data port, swap on/off
    wr(5'd1, 32'h2);
    wr(5'd7, 32'h1234); wait_idle();
    check("R8 swapped write", {16'b0, last_wr_dd}, 32'h3412);
    check("R8 data address", {29'b0, last_da}, 32'h0);
    dev_rd = 16'hBEEF;
    rd(5'd7, v); rd(5'd6, v);
    check("R8 swapped read", v, 32'h0000EFBE);
    wr(5'd1, 32'h0);
    wr(5'd7, 32'hABCD); wait_idle();
    check("R8 straight write", {16'b0, last_wr_dd}, 32'hABCD);
    rd(5'd7, v); rd(5'd6, v);
    check("R8 straight read", v, 32'h0000BEEF);

    // zero counts
    wr(5'd2, 32'h0);
    clr_cnt();
    wr(5'd7, 32'h5555); wait_idle();
    check("R2 one-clock strobe", wr_low, 1);
    check("R2 three-clock cycle", busy_cnt, 3);

    // IORDY ignored when disabled
    wr(5'd2, 32'h01021);
    iordy = 1'b0;
    clr_cnt();
    rd(5'd7, v); wait_idle();
    check("R4 iordy ignored", rd_low, 2);

    // IORDY stretch
    wr(5'd1, 32'h1);
    clr_cnt();
    rd(5'd7, v);
    repeat (6) @(negedge clk);
    iordy = 1'b1;
    wait_idle();
    check("R4 strobe stretched", rd_low, 6);
    wr(5'd1, 32'h0);

    // back-to-back device accesses
    wr(5'd2, 32'h02032);
    clr_cnt();
    wr(5'd7, 32'h0001);
    host_acc(1'b1, 5'd7, 32'h0002, v, w);
    check("R6 second access waited", {31'b0, w > 0}, 32'h1);
    wait_idle();
    check("R6 both cycles ran", wr_low, 6);

    // interrupts
    rd(5'd4, v); check("R9 completion flag", v, 32'h1);
    check("R10 masked off", {31'b0, irq_o}, 32'h0);
    wr(5'd5, 32'h1);
    check("R10 unmasked", {31'b0, irq_o}, 32'h1);
    wr(5'd4, 32'h1);
    rd(5'd4, v); check("R9 w1c clears", v, 32'h0);
    check("R10 low after clear", {31'b0, irq_o}, 32'h0);
    intrq = 1'b1;
    repeat (4) @(negedge clk);
    rd(5'd4, v); check("R9 intrq edge", v, 32'h2);
    wr(5'd5, 32'h2);
    check("R10 intrq unmasked", {31'b0, irq_o}, 32'h1);
    wr(5'd4, 32'h1);
    rd(5'd4, v); check("R9 other bit kept", v, 32'h2);
    wr(5'd4, 32'h2);
    rd(5'd4, v); check("R9 intrq cleared", v, 32'h0);
    rd(5'd5, v); check("R11 mask readback", v, 32'h2);

    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule